// File: doc/BRIEF.md
# Crypto Capability Table Matcher

This block keeps a small table of crypto capability entries. Each entry carries an algorithm identifier, a key-size code and a bitmask of the data-unit sizes it supports. A lookup names an algorithm, a key-size code and a data-unit size in bytes. The block turns the byte size into a one-hot unit mask and walks the table, one entry per clock, looking for an entry that serves the request.

The table is filled through a one-entry-per-cycle write port. A global capability word and an advertised entry count come in as inputs. A zero capability word turns every lookup into a failure. Only indices below the advertised count, clamped to the table depth, take part in a search. A request that cannot match is rejected at the start edge without a scan. Such a request has an unusable size, an invalid key-size code, a zero capability word or a zero count. For every lookup the block also reports the key length in bytes that the requested key-size code stands for.

Top module: `cap_match`

## Requirements
- R1: The unit mask is the byte size divided by 512 and is nonzero only for powers of two from 512 to 65536 inclusive. Mask bit n stands for 512 shifted left by n. Any other size, including 0, gives a zero mask, and the lookup then fails with `found` = 0.
- R2: An entry matches only when its algorithm field equals `req_alg`, its key-size field equals `req_ksz`, and its size mask ANDed with the unit mask is nonzero.
- R3: When several entries match, the lowest index is reported.
- R4: When `cap_word` is zero, every lookup fails, with `done` one edge after the start edge and `found` = 0.
- R5: Only indices below min(`cap_count`, ENTRIES) are searched. A count of zero fails at once.
- R6: Key-size code 1, 2, 3 and 4 give `key_len` 16, 24, 32 and 64 bytes. Any other code gives 0, and the lookup fails at once.
- R7: Latency is counted in edges, with the edge that samples `start` counted as edge 1. A hit at index k raises `done` at edge k+2. A full miss raises it at edge count+1. An early rejection raises it at edge 1. `done` lasts one cycle, and `busy` is low while `done` is high. On a miss, `match_idx` reads 0.
- R8: A `start` pulse while `busy` is high is ignored. It neither changes the running lookup nor produces an extra `done`.
- R9: A table write that lands on the edge that evaluates the same entry does not affect that evaluation. The scan sees the old contents, and the new contents apply from the next edge.
- R10: After reset, `busy`, `done`, `found`, `match_idx` and `key_len` are all zero, and the table is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry to write |
| wr_alg | input | ALG_W | Algorithm field to write |
| wr_ksz | input | KSZ_W | Key-size code to write |
| wr_mask | input | MASK_W | Supported unit-size mask to write |
| cap_word | input | CAP_W | Global support word; zero means unsupported |
| cap_count | input | CNT_W | Advertised number of valid entries |
| start | input | 1 | Lookup request pulse |
| req_alg | input | ALG_W | Requested algorithm |
| req_ksz | input | KSZ_W | Requested key-size code |
| req_bytes | input | BYTES_W | Requested data-unit size in bytes |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | Last lookup matched |
| match_idx | output | IDX_W | Index of the match, 0 on a miss |
| key_len | output | 7 | Key length in bytes of the requested code |

## Verification
Two things can fall in the same cycle: a table write and the scan step that reads the same entry. The bench provokes this by writing entry 0 on the edge that evaluates index 0. It expects the old contents to decide the result, and it then checks that a repeat lookup sees the new contents. The second overlap is a fresh `start` arriving while a full-length miss is still scanning. The bench judges this by counting `done` pulses, requiring exactly one of them at the edge the first request predicts, with that request's result.

// File: rtl/cap_match.sv
module cap_match #(
  parameter int ENTRIES    = 8,
  parameter int ALG_W      = 8,
  parameter int KSZ_W      = 8,
  parameter int MASK_W     = 8,
  parameter int BYTES_W    = 32,
  parameter int CNT_W      = 8,
  parameter int CAP_W      = 32,
  parameter int UNIT_BYTES = 512,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ALG_W-1:0]   wr_alg,
  input  logic [KSZ_W-1:0]   wr_ksz,
  input  logic [MASK_W-1:0]  wr_mask,
  input  logic [CAP_W-1:0]   cap_word,
  input  logic [CNT_W-1:0]   cap_count,
  input  logic               start,
  input  logic [ALG_W-1:0]   req_alg,
  input  logic [KSZ_W-1:0]   req_ksz,
  input  logic [BYTES_W-1:0] req_bytes,
  output logic               busy,
  output logic               done,
  output logic               found,
  output logic [IDX_W-1:0]   match_idx,
  output logic [6:0]         key_len
);
  localparam int LOW_BITS = $clog2(UNIT_BYTES);

  function automatic logic [6:0] len_of(input logic [KSZ_W-1:0] code);
    case (code)
      KSZ_W'(1): return 7'd16;
      KSZ_W'(2): return 7'd24;
      KSZ_W'(3): return 7'd32;
      KSZ_W'(4): return 7'd64;
      default:   return 7'd0;
    endcase
  endfunction

  logic [ALG_W-1:0]  t_alg  [ENTRIES];
  logic [KSZ_W-1:0]  t_ksz  [ENTRIES];
  logic [MASK_W-1:0] t_mask [ENTRIES];

  logic [BYTES_W-1:0] units;
  logic               size_ok;
  logic [MASK_W-1:0]  req_mask;
  logic [6:0]         req_len;
  logic [CNT_W-1:0]   lim;
  logic               reject;

  assign units    = req_bytes >> LOW_BITS;
  assign size_ok  = (req_bytes[LOW_BITS-1:0] == '0) && ((units >> MASK_W) == '0) && $onehot(units);
  assign req_mask = size_ok ? units[MASK_W-1:0] : '0;
  assign req_len  = len_of(req_ksz);
  assign lim      = (cap_count > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : cap_count;
  assign reject   = (cap_word == '0) || (req_mask == '0) || (req_len == 7'd0) || (lim == '0);

  logic [ALG_W-1:0]  alg_q;
  logic [KSZ_W-1:0]  ksz_q;
  logic [MASK_W-1:0] mask_q;
  logic [CNT_W-1:0]  lim_q;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              last;

  assign hit  = (t_alg[idx] == alg_q) && (t_ksz[idx] == ksz_q) && ((t_mask[idx] & mask_q) != '0);
  assign last = (CNT_W'(idx) + CNT_W'(1)) == lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        t_alg[i]  <= '0;
        t_ksz[i]  <= '0;
        t_mask[i] <= '0;
      end
    end else if (wr_en) begin
      t_alg[wr_idx]  <= wr_alg;
      t_ksz[wr_idx]  <= wr_ksz;
      t_mask[wr_idx] <= wr_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      found     <= 1'b0;
      match_idx <= '0;
      key_len   <= '0;
      alg_q     <= '0;
      ksz_q     <= '0;
      mask_q    <= '0;
      lim_q     <= '0;
      idx       <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        alg_q     <= req_alg;
        ksz_q     <= req_ksz;
        mask_q    <= req_mask;
        lim_q     <= lim;
        key_len   <= req_len;
        found     <= 1'b0;
        match_idx <= '0;
        idx       <= '0;
        if (reject) done <= 1'b1;
        else        busy <= 1'b1;
      end else if (busy) begin
        if (hit) begin
          done      <= 1'b1;
          found     <= 1'b1;
          match_idx <= idx;
          busy      <= 1'b0;
        end else if (last) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cap_match_chk.sv
module cap_match_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 8,
  parameter int ALG_W   = 8,
  parameter int BYTES_W = 32,
  parameter int CAP_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               found,
  input logic [IDX_W-1:0]   match_idx,
  input logic [CAP_W-1:0]   cap_word,
  input logic [BYTES_W-1:0] req_bytes,
  input logic [CNT_W-1:0]   lim_q,
  input logic [ALG_W-1:0]   alg_q
);
  logic [15:0] busy_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cyc <= '0;
    else if (busy)  busy_cyc <= busy_cyc + 16'd1;
    else            busy_cyc <= '0;
  end

  assert_unsupported_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cap_word == '0) |=> (done && !found));

  assert_bad_size_fails_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((req_bytes & (req_bytes - 1'b1)) != '0)) |=> (done && !found));

  assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (CNT_W'(match_idx) < lim_q));

  assert_scan_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cyc < 16'(ENTRIES)));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(alg_q));
endmodule

bind cap_match cap_match_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W),
  .ALG_W(ALG_W), .BYTES_W(BYTES_W), .CAP_W(CAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .found(found), .match_idx(match_idx), .cap_word(cap_word),
  .req_bytes(req_bytes), .lim_q(lim_q), .alg_q(alg_q)
);

// File: tb/tb_cap_match.sv
`timescale 1ns/1ps
module tb_cap_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [7:0]  wr_alg = '0, wr_ksz = '0, wr_mask = '0;
  logic [31:0] cap_word = 32'h1;
  logic [7:0]  cap_count = 8'd8;
  logic        start = 1'b0;
  logic [7:0]  req_alg = '0, req_ksz = '0;
  logic [31:0] req_bytes = '0;
  logic        busy, done, found;
  logic [2:0]  match_idx;
  logic [6:0]  key_len;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cap_match dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_alg(wr_alg),
    .wr_ksz(wr_ksz), .wr_mask(wr_mask), .cap_word(cap_word), .cap_count(cap_count),
    .start(start), .req_alg(req_alg), .req_ksz(req_ksz), .req_bytes(req_bytes),
    .busy(busy), .done(done), .found(found), .match_idx(match_idx), .key_len(key_len)
  );

  // {alg, ksz, bytes, found, idx, key_len}
  localparam int NV = 17;
  localparam logic [58:0] VEC [NV] = '{
    {8'd1, 8'd3, 32'd512,    1'b1, 3'd0, 7'd32},
    {8'd1, 8'd3, 32'd4096,   1'b1, 3'd1, 7'd32},
    {8'd1, 8'd3, 32'd2048,   1'b1, 3'd3, 7'd32},
    {8'd2, 8'd1, 32'd16384,  1'b1, 3'd2, 7'd16},
    {8'd3, 8'd4, 32'd65536,  1'b1, 3'd4, 7'd64},
    {8'd1, 8'd2, 32'd512,    1'b1, 3'd5, 7'd24},
    {8'd1, 8'd2, 32'd1024,   1'b0, 3'd0, 7'd24},
    {8'd4, 8'd3, 32'd8192,   1'b1, 3'd6, 7'd32},
    {8'd5, 8'd1, 32'd1024,   1'b1, 3'd7, 7'd16},
    {8'd1, 8'd3, 32'd768,    1'b0, 3'd0, 7'd32},
    {8'd2, 8'd1, 32'd256,    1'b0, 3'd0, 7'd16},
    {8'd2, 8'd1, 32'd131072, 1'b0, 3'd0, 7'd16},
    {8'd2, 8'd1, 32'd0,      1'b0, 3'd0, 7'd16},
    {8'd1, 8'd7, 32'd512,    1'b0, 3'd0, 7'd0},
    {8'd9, 8'd3, 32'd512,    1'b0, 3'd0, 7'd32},
    {8'd2, 8'd1, 32'd513,    1'b0, 3'd0, 7'd16},
    {8'd2, 8'd4, 32'd1024,   1'b0, 3'd0, 7'd64}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic bit size_valid(input logic [31:0] b);
    return b >= 512 && b <= 65536 && (b & (b - 1)) == 0;
  endfunction

  task automatic wr(input logic [2:0] i, input logic [7:0] a, k, m);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_alg = a; wr_ksz = k; wr_mask = m;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] a, k, input logic [31:0] b, output int lat);
    @(negedge clk);
    req_alg = a; req_ksz = k; req_bytes = b; start = 1'b1; lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end while (!done && lat < 40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R7: actual=hung expected=done");
    report();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !found, "R10 flags after reset", {busy, done, found}, 0);
    check(match_idx == 0 && key_len == 0, "R10 index/len after reset", key_len, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 cleared table: alg 0 / code 1 request finds nothing in a zero table
    lookup(8'd0, 8'd1, 32'd512, lat);
    check(!found, "R10 cleared table no match", found, 0);
    check(lat == 9, "R10 cleared table full scan", lat, 9);

    wr(3'd0, 8'd1, 8'd3, 8'h01);
    wr(3'd1, 8'd1, 8'd3, 8'h08);
    wr(3'd2, 8'd2, 8'd1, 8'hFF);
    wr(3'd3, 8'd1, 8'd3, 8'h0C);
    wr(3'd4, 8'd3, 8'd4, 8'h80);
    wr(3'd5, 8'd1, 8'd2, 8'h01);
    wr(3'd6, 8'd4, 8'd3, 8'h10);
    wr(3'd7, 8'd5, 8'd1, 8'h02);

    // R1 R2 R3 R6 R7 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [58:0] e;
      bit early;
      int exp_lat;
      e = VEC[v];
      early = !size_valid(e[42:11]) || e[6:0] == 0;
      exp_lat = e[10] ? int'(e[9:7]) + 2 : (early ? 1 : 9);
      lookup(e[58:51], e[50:43], e[42:11], lat);
      check(found == e[10], $sformatf("R1/R2 vector %0d found", v), found, e[10]);
      check(match_idx == e[9:7], $sformatf("R3 vector %0d index", v), match_idx, e[9:7]);
      check(key_len == e[6:0], $sformatf("R6 vector %0d key_len", v), key_len, e[6:0]);
      check(lat == exp_lat, $sformatf("R7 vector %0d latency", v), lat, exp_lat);
    end

    // R4 zero support word
    cap_word = 32'h0;
    lookup(8'd1, 8'd3, 32'd512, lat);
    check(!found, "R4 zero word fails", found, 0);
    check(lat == 1, "R4 zero word latency", lat, 1);
    cap_word = 32'hA5;

    // R5 count limits
    cap_count = 8'd7;
    lookup(8'd5, 8'd1, 32'd1024, lat);
    check(!found, "R5 entry at count excluded", found, 0);
    check(lat == 8, "R5 scan stops at count", lat, 8);
    cap_count = 8'd3;
    lookup(8'd1, 8'd3, 32'd2048, lat);
    check(!found && lat == 4, "R5 count 3 miss", lat, 4);
    cap_count = 8'd0;
    lookup(8'd1, 8'd3, 32'd512, lat);
    check(!found && lat == 1, "R5 count zero rejects", lat, 1);
    cap_count = 8'd200;
    lookup(8'd9, 8'd3, 32'd512, lat);
    check(!found && lat == 9, "R5 count clamped to depth", lat, 9);
    lookup(8'd5, 8'd1, 32'd1024, lat);
    check(found && match_idx == 7, "R5 clamped count finds last", match_idx, 7);
    cap_count = 8'd8;

    // R8 start while busy ignored
    begin
      int ndone = 0, first = 0;
      bit f_at = 1'b1;
      @(negedge clk);
      req_alg = 8'd9; req_ksz = 8'd3; req_bytes = 32'd512; start = 1'b1;
      for (int c = 1; c <= 14; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (c == 1) begin req_alg = 8'd1; start = 1'b1; end
        else start = 1'b0;
        if (done) begin
          ndone++;
          if (first == 0) begin first = c; f_at = found; end
        end
      end
      check(ndone == 1, "R8 single done", ndone, 1);
      check(first == 9, "R8 done edge of first request", first, 9);
      check(!f_at, "R8 first request result kept", f_at, 0);
    end

    // R9 write to the entry being evaluated
    @(negedge clk);
    req_alg = 8'd1; req_ksz = 8'd3; req_bytes = 32'd512; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wr_en = 1'b1; wr_idx = 3'd0; wr_alg = 8'd9; wr_ksz = 8'd3; wr_mask = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check(done && found && match_idx == 0, "R9 scan used old entry", {done, found}, 3);
    lookup(8'd1, 8'd3, 32'd512, lat);
    check(!found && lat == 9, "R9 new entry applies after", lat, 9);
    lookup(8'd9, 8'd3, 32'd512, lat);
    check(found && match_idx == 0 && lat == 2, "R9 rewritten entry matches", lat, 2);

    report();
  end
endmodule